// File: doc/BRIEF.md
# Dual-Line Two-Edge PDM Capture Router

This block is the front end of a multi-microphone PDM capture path. Up to four pulse-density microphones share two data lines. On each line, one microphone drives its bit while the bit clock is high and the other drives while the clock is low. The block is always the clock master. It divides the system clock into the PDM bit clock, which runs only while at least one logical channel is enabled. It passes both data pins through a two-flop synchronizer and samples each line twice per bit clock period, once just before each clock transition.

Each of the four logical channels picks its own source pair: one data line and one clock phase. This lets any microphone be remapped to any channel. Every enabled channel gives one data bit and a one-cycle strobe per bit clock period for a downstream decimator. Microphones need time to settle after their clock appears. For that reason, a fresh start of the bit clock is followed by a configurable number of whole periods during which no strobes are issued.

Top module: `pdm_lane_router`

## Requirements
- R1: While reset is held and in the cycles right after it, `pdm_clk` is low, `ch_stb` is all zero and `ch_bit` is all zero.
- R2: While any bit of `ch_en` is set, `pdm_clk` toggles every HALF_DIV system cycles, so its period is 2*HALF_DIV cycles. While `ch_en` is zero, `pdm_clk` is held low and never rises.
- R3: `edge_sel[n]`=0 selects the microphone that drives on the rising edge. Its bit is taken in the last system cycle before the falling edge, and the strobe appears while `pdm_clk` is low. `edge_sel[n]`=1 selects the microphone that drives on the falling edge, and its strobe appears while `pdm_clk` is high.
- R4: `line_sel[n]`=0 routes data pin `pdm_din[0]` to channel n, and `line_sel[n]`=1 routes `pdm_din[1]`. Both pins pass through a two-stage synchronizer before sampling. With `ch_stb[n]` high, `ch_bit[n]` equals the bit that the selected microphone drove in the current bit clock phase pair.
- R5: Once warm-up is over, an enabled channel strobes exactly once per bit clock period, and never in two consecutive cycles.
- R6: A channel with its `ch_en` bit clear produces no strobe. Clearing the bit stops that channel's strobes within two cycles and leaves the other channels unaffected.
- R7: After the bit clock starts from idle, the first strobe on any channel comes after exactly WARMUP_PERIODS+1 rising edges of `pdm_clk` have occurred, and before the next rising edge.
- R8: Channels are mapped independently. Several channels that select the same (line, phase) pair give identical bits on the same strobes.
- R9: Clearing all enables stops the bit clock and re-arms the warm-up, so a later start again waits WARMUP_PERIODS+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel enable |
| line_sel | input | NUM_CH | Per-channel data line select (0: pin 0, 1: pin 1) |
| edge_sel | input | NUM_CH | Per-channel phase select (0: rising-edge microphone, 1: falling-edge microphone) |
| pdm_din | input | 2 | Asynchronous PDM data pins |
| pdm_clk | output | 1 | PDM bit clock driven to the microphones |
| ch_bit | output | NUM_CH | Captured data bit per channel |
| ch_stb | output | NUM_CH | One-cycle strobe per channel marking a new bit |

## Verification
The bench models four microphones that drive new random bits on their own clock phase, multiplexed onto the two pins. It checks every strobed bit against the microphone the channel selects. A design that sampled on the wrong side of a clock edge, or skipped the synchronizer latency, would return the neighbouring microphone's bit. A swapped line or phase decode would show up as bit mismatches under random remappings, including mappings where several channels share one pair. It counts the rising edges before the first strobe of each fresh start, which catches an off-by-one warm-up or a warm-up that is not re-armed after a full stop. It also counts strobes per channel over fixed windows, which catches missing, doubled or ungated strobes.

// File: rtl/pdm_router_pkg.sv
package pdm_router_pkg;

    // number of shared data pins; each carries two microphones
    localparam int unsigned PDM_LINES = 2;

    typedef enum logic {
        PHASE_RISE = 1'b0,   // microphone drives after the rising edge
        PHASE_FALL = 1'b1    // microphone drives after the falling edge
    } mic_phase_e;

    // latest bit captured from one line, one slot per microphone phase
    typedef struct packed {
        logic fall_bit;
        logic rise_bit;
    } line_smp_t;

    // capture instants inside a bit clock period
    typedef struct packed {
        logic rise;   // end of the high half: rising-phase data valid
        logic fall;   // end of the low half: falling-phase data valid
    } cap_evt_t;

    function automatic logic pick_phase(line_smp_t s, mic_phase_e ph);
        return (ph == PHASE_FALL) ? s.fall_bit : s.rise_bit;
    endfunction

endpackage

// File: rtl/pdm_bitclk_gen.sv
module pdm_bitclk_gen
    import pdm_router_pkg::*;
#(
    parameter int unsigned HALF_DIV       = 4,
    parameter int unsigned WARMUP_PERIODS = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    output logic     bit_clk,
    output cap_evt_t cap,
    output logic     settled
);
    localparam int unsigned DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int unsigned WARM_W = (WARMUP_PERIODS > 1) ? $clog2(WARMUP_PERIODS) : 1;

    logic [DIV_W-1:0] div_q;
    logic             clk_q;
    logic             half_end;

    assign half_end = (div_q == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            clk_q <= 1'b0;
        end else if (half_end) begin
            div_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign bit_clk  = clk_q;
    assign cap.rise = run &  clk_q & half_end;
    assign cap.fall = run & ~clk_q & half_end;

    generate
        if (WARMUP_PERIODS == 0) begin : g_no_warm
            assign settled = 1'b1;
        end else begin : g_warm
            logic [WARM_W-1:0] per_q;
            logic              done_q;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    per_q  <= '0;
                    done_q <= 1'b0;
                end else if (cap.rise && !done_q) begin
                    if (per_q == WARM_W'(WARMUP_PERIODS - 1)) begin
                        done_q <= 1'b1;
                    end else begin
                        per_q <= per_q + WARM_W'(1);
                    end
                end
            end
            assign settled = done_q;
        end
    endgenerate

endmodule

// File: rtl/pdm_in_sync.sv
module pdm_in_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture
    import pdm_router_pkg::*;
#(
    parameter int unsigned LINES = PDM_LINES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINES-1:0]      din_sync,
    input  cap_evt_t              cap,
    input  logic                  settled,
    output line_smp_t [LINES-1:0] smp,
    output cap_evt_t              evt
);
    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    smp[l] <= '0;
                end else begin
                    if (cap.rise) smp[l].rise_bit <= din_sync[l];
                    if (cap.fall) smp[l].fall_bit <= din_sync[l];
                end
            end
        end
    endgenerate

    // events are only released once the microphones have settled
    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt.rise <= cap.rise & settled;
            evt.fall <= cap.fall & settled;
        end
    end

endmodule

// File: rtl/pdm_chan_route.sv
module pdm_chan_route
    import pdm_router_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned LINES  = PDM_LINES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  line_smp_t [LINES-1:0] smp,
    input  cap_evt_t              evt,
    input  logic [NUM_CH-1:0]     ch_en,
    input  logic [NUM_CH-1:0]     line_sel,
    input  logic [NUM_CH-1:0]     edge_sel,
    output logic [NUM_CH-1:0]     ch_bit,
    output logic [NUM_CH-1:0]     ch_stb
);
    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            mic_phase_e ph;
            line_smp_t  src;
            logic       hit;

            assign ph  = mic_phase_e'(edge_sel[n]);
            assign src = smp[line_sel[n]];
            assign hit = ch_en[n] & ((ph == PHASE_FALL) ? evt.fall : evt.rise);

            always_ff @(posedge clk) begin
                if (rst) begin
                    ch_stb[n] <= 1'b0;
                    ch_bit[n] <= 1'b0;
                end else begin
                    ch_stb[n] <= hit;
                    if (hit) ch_bit[n] <= pick_phase(src, ph);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pdm_lane_router.sv
module pdm_lane_router
    import pdm_router_pkg::*;
#(
    parameter int unsigned NUM_CH         = 4,
    parameter int unsigned HALF_DIV       = 4,
    parameter int unsigned WARMUP_PERIODS = 4,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] line_sel,
    input  logic [NUM_CH-1:0] edge_sel,
    input  logic [1:0]        pdm_din,
    output logic              pdm_clk,
    output logic [NUM_CH-1:0] ch_bit,
    output logic [NUM_CH-1:0] ch_stb
);
    // the capture point must see the synchronized pin settle inside one half
    initial begin
        if (HALF_DIV < SYNC_STAGES + 1)
            $error("HALF_DIV too small for the synchronizer latency");
    end

    logic                      run;
    cap_evt_t                  cap;
    cap_evt_t                  evt;
    logic                      settled;
    logic [PDM_LINES-1:0]      din_sync;
    line_smp_t [PDM_LINES-1:0] smp;

    assign run = |ch_en;

    pdm_bitclk_gen #(
        .HALF_DIV      (HALF_DIV),
        .WARMUP_PERIODS(WARMUP_PERIODS)
    ) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .bit_clk(pdm_clk),
        .cap    (cap),
        .settled(settled)
    );

    pdm_in_sync #(
        .WIDTH (PDM_LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pdm_din),
        .q  (din_sync)
    );

    pdm_edge_capture #(
        .LINES(PDM_LINES)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .din_sync(din_sync),
        .cap     (cap),
        .settled (settled),
        .smp     (smp),
        .evt     (evt)
    );

    pdm_chan_route #(
        .NUM_CH(NUM_CH),
        .LINES (PDM_LINES)
    ) u_route (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .evt     (evt),
        .ch_en   (ch_en),
        .line_sel(line_sel),
        .edge_sel(edge_sel),
        .ch_bit  (ch_bit),
        .ch_stb  (ch_stb)
    );

endmodule

// File: rtl/pdm_lane_router_chk.sv
module pdm_lane_router_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] edge_sel,
    input logic              pdm_clk,
    input logic [NUM_CH-1:0] ch_stb
);
    // R2: a clock half lasts more than one system cycle
    assert_clk_high_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pdm_clk) |=> pdm_clk);
    assert_clk_low_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pdm_clk) |=> !pdm_clk);

    // R2: with every channel off the bit clock parks low
    assert_clk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (ch_en == '0) |=> !pdm_clk);

    // R6: a strobe needs the channel enabled in the cycle it was produced
    assert_stb_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        (ch_stb & ~$past(ch_en)) == '0);

    // R5: no channel strobes in two consecutive cycles
    assert_stb_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (ch_stb & $past(ch_stb)) == '0);

    // R3: the strobe lands in the clock half matching the selected phase
    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_phase
            assert_stb_phase_R3: assert property (@(posedge clk) disable iff (rst)
                ch_stb[n] |-> (pdm_clk == $past(edge_sel[n])));
        end
    endgenerate

endmodule

bind pdm_lane_router pdm_lane_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ch_en   (ch_en),
    .edge_sel(edge_sel),
    .pdm_clk (pdm_clk),
    .ch_stb  (ch_stb)
);

// File: tb/pdm_lane_router_bench.sv
module pdm_lane_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int HALF  = 4;
    localparam int WARM  = 4;
    localparam int PER   = 2 * HALF;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] line_sel = '0;
    logic [NCH-1:0] edge_sel = '0;
    logic [1:0]     pdm_din = '0;
    logic           pdm_clk;
    logic [NCH-1:0] ch_bit;
    logic [NCH-1:0] ch_stb;

    int tests = 0;
    int errs  = 0;

    // microphone model: bits driven by rising-phase and falling-phase mics per line
    logic [1:0] mic_r = '0;
    logic [1:0] mic_f = '0;
    logic       prev_clk = 1'b0;
    int         rise_cnt = 0;
    int         first_rise = -1;
    bit         first_seen = 0;
    int         cfg_age = 0;
    int         since_rise = 0;
    bit         rise_valid = 0;
    int         stb_cnt [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_lane_router #(
        .NUM_CH(NCH), .HALF_DIV(HALF), .WARMUP_PERIODS(WARM), .SYNC_STAGES(2)
    ) u_pdm_lane_router (
        .clk(clk), .rst(rst), .ch_en(ch_en), .line_sel(line_sel),
        .edge_sel(edge_sel), .pdm_din(pdm_din), .pdm_clk(pdm_clk),
        .ch_bit(ch_bit), .ch_stb(ch_stb)
    );

    function automatic logic expect_bit(logic ln, logic ed, logic [1:0] r, logic [1:0] f);
        return ed ? f[ln] : r[ln];
    endfunction

    task automatic check_eq(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor and microphone model, all at the falling system edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int n = 0; n < NCH; n++) begin
                if (ch_stb[n]) begin
                    if (!first_seen) begin
                        first_seen = 1;
                        first_rise = rise_cnt;
                    end
                    stb_cnt[n]++;
                    if (cfg_age >= 4) begin
                        logic e;
                        e = expect_bit(line_sel[n], edge_sel[n], mic_r, mic_f);
                        tests++;
                        if (ch_bit[n] !== e) begin
                            errs++;
                            $display("FAIL R3 R4 R8: ch%0d bit got %0d expected %0d", n, ch_bit[n], e);
                        end
                    end
                    if (!ch_en[n] && cfg_age >= 3) begin
                        errs++;
                        $display("FAIL R6: ch%0d strobe got 1 expected 0", n);
                    end
                end
            end
            if (cfg_age < 1000) cfg_age++;
            since_rise++;
            if (ch_en == '0) rise_valid = 0;
            if (pdm_clk && !prev_clk) begin
                rise_cnt++;
                if (rise_valid) check_eq("R2 period", since_rise, PER);
                rise_valid = (ch_en != '0);
                since_rise = 0;
                mic_r = 2'($urandom);
            end
            if (!pdm_clk && prev_clk) mic_f = 2'($urandom);
            prev_clk = pdm_clk;
            for (int l = 0; l < 2; l++) pdm_din[l] = pdm_clk ? mic_r[l] : mic_f[l];
        end
    end

    task automatic apply_cfg(logic [NCH-1:0] en, logic [NCH-1:0] ln, logic [NCH-1:0] ed);
        @(posedge clk); #1;
        ch_en = en; line_sel = ln; edge_sel = ed;
        cfg_age = 0;
    endtask

    task automatic fresh_start(logic [NCH-1:0] en, logic [NCH-1:0] ln, logic [NCH-1:0] ed);
        apply_cfg('0, ln, ed);
        repeat (12) @(posedge clk);
        #1;
        rise_cnt = 0; first_seen = 0; first_rise = -1;
        apply_cfg(en, ln, ed);
    endtask

    task automatic count_window(int periods, logic [NCH-1:0] en, string req);
        @(posedge clk); #1;
        for (int n = 0; n < NCH; n++) stb_cnt[n] = 0;
        repeat (PER * periods) @(posedge clk);
        #1;
        for (int n = 0; n < NCH; n++)
            check_eq(req, stb_cnt[n], en[n] ? periods : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int n = 0; n < NCH; n++) stb_cnt[n] = 0;
        repeat (5) @(posedge clk);
        // R1: state under reset
        #1;
        check_eq("R1 clk in reset", int'(pdm_clk), 0);
        check_eq("R1 stb in reset", int'(ch_stb), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_eq("R1 clk after reset", int'(pdm_clk), 0);
        check_eq("R1 bit after reset", int'(ch_bit), 0);
        check_eq("R1 stb after reset", int'(ch_stb), 0);

        // R7: warm-up on a fresh start, identity mapping of four mics
        fresh_start(4'b1111, 4'b1100, 4'b1010);
        repeat (PER * (WARM + 3)) @(posedge clk);
        check_eq("R7 rises before first strobe", first_rise, WARM + 1);
        // R5: one strobe per period per enabled channel
        count_window(6, 4'b1111, "R5 strobe count");

        // R6: drop one channel, others unaffected
        apply_cfg(4'b1011, 4'b1100, 4'b1010);
        repeat (4) @(posedge clk);
        count_window(5, 4'b1011, "R6 disabled channel");

        // R8: every channel on the same (line 1, falling) pair
        apply_cfg(4'b1111, 4'b1111, 4'b1111);
        repeat (PER * 2) @(posedge clk);
        count_window(5, 4'b1111, "R8 shared pair count");
        // R4: every channel on line 0 rising phase
        apply_cfg(4'b1111, 4'b0000, 4'b0000);
        repeat (PER * 2) @(posedge clk);
        count_window(5, 4'b1111, "R4 line0 count");

        // random remappings (R3 R4 R5 R6 R8)
        for (int t = 0; t < 14; t++) begin
            logic [NCH-1:0] en;
            en = NCH'(($urandom % 15) + 1);
            apply_cfg(en, NCH'($urandom), NCH'($urandom));
            repeat (PER * 2) @(posedge clk);
            count_window(6, en, "R5 R6 random count");
        end

        // R9: full stop parks the clock, restart re-arms warm-up
        apply_cfg('0, 4'b0101, 4'b0011);
        repeat (4) @(posedge clk);
        #1;
        rise_cnt = 0;
        repeat (40) @(posedge clk);
        #1;
        check_eq("R2 R9 idle rises", rise_cnt, 0);
        check_eq("R2 R9 idle clk level", int'(pdm_clk), 0);
        fresh_start(4'b0110, 4'b0101, 4'b0011);
        repeat (PER * (WARM + 3)) @(posedge clk);
        check_eq("R9 rises before first strobe after restart", first_rise, WARM + 1);
        count_window(4, 4'b0110, "R9 strobe count after restart");

        $display("  [TB] %0d tests run, %0d failed", tests, errs);
        $finish;
    end

endmodule